// File: doc/BRIEF.md
# Parallel-Port Nibble Register Interface

This block is the device-side register front end of a network adapter that hangs off a PC parallel port. The host can only write whole bytes to the port's 8-bit data lines and can only read a few status lines back. Each data-port byte therefore carries three fields: a 3-bit command in bits 7:5, a nibble-select flag in bit 4 and a 4-bit payload in bits 3:0. The block decodes these bytes into register address, register write and register read cycles. During a read it returns the chosen nibble on status lines 6:3, and the host recovers it as `(status >> 3) & 0xF`.

There is a 16-entry register file. Each entry has a low and a high nibble half. Two entries drive the adapter's control outputs. Command-1 (index 12), high nibble: bit 3 selects the multiplexer, bit 2 is a soft reset, bit 1 enables receive and bit 0 enables transmit. Command-2 (index 13): the two low bits of its high nibble set the address-accept mode. A small byte buffer with an auto-incrementing pointer stands in for packet memory. The host fills it with nibble pairs outside any register access and drains it by reading index 14.

Top module: `pnr_nibble_port`

## Requirements
- R1: After reset, host_status, tx_enable, rx_enable, mux_sel and accept_mode are all zero. Every register and the buffer pointer are zero.
- R2: A data-port byte takes effect only when its bits 7:4 differ from those of the previous written byte. Repeating a byte, or changing only bits 3:0, changes no output or state.
- R3: The sequence 0xE0|a, 0x40|a, 0x40|a, 0x40|v, v, v, 0xE0|v writes v into the low nibble of register a. The write happens on the first byte with command 000 that follows a command-010 address byte.
- R4: The same sequence with bit 4 set in every byte writes v into the high nibble of register a and leaves the low nibble unchanged.
- R5: Command 110 (0xC0) latches bits 3:0 as the read address and bit 4 as the nibble select. While reading, host_status bits 6:3 carry the selected nibble and bits 7 and 2:0 are zero.
- R6: Command 111 (0xE0) ends the access. host_status returns to zero, and later command-000 bytes go to the byte buffer instead of a register.
- R7: In command-1 (index 12), high nibble bit 3 drives mux_sel, bit 1 drives rx_enable and bit 0 drives tx_enable.
- R8: accept_mode equals bits 1:0 of the command-2 (index 13) high nibble. The values are 0 none, 1 station match, 2 station plus broadcast, 3 all.
- R9: With no access open, a command-000 byte with bit 4 clear holds a low nibble. The next one with bit 4 set stores the full byte at the pointer, and the pointer then increments.
- R10: In read mode at index 14, bit 4 clear returns the low nibble and bit 4 set returns the high nibble of the buffer byte at the pointer. The next accepted byte after a high-nibble read advances the pointer.
- R11: Writing a high nibble with bit 2 set into index 12 clears registers 12 and 13 and the buffer pointer. Buffer contents are kept.
- R12: The buffer pointer wraps from depth-1 to 0. Depth is a power of two, 16 by default.
- R13: The single-access sequence 0x40|lo, lo, hi, 0x10|hi writes a whole byte. The middle byte (command 000, bit 4 clear, payload changed) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | One-cycle pulse marking a new data-port byte |
| host_data | input | 8 | Data-port byte: command, nibble select, payload |
| host_status | output | 8 | Status lines; read nibble on bits 6:3 |
| tx_enable | output | 1 | Transmit unit enable |
| rx_enable | output | 1 | Receive unit enable |
| mux_sel | output | 1 | Multiplexer select |
| accept_mode | output | 2 | Address-accept mode |

## Verification
The assertions check four things on every cycle. A byte whose upper four bits repeat leaves the outputs and the pointer untouched. An end command always blanks the status lines. The pointer only holds, steps by one or returns to zero. A soft-reset write clears the controls and the pointer. The bench scenarios cover what needs a stored history: read-back of low and high nibble writes, whole-byte writes inside one access, the control bit mapping, the buffer fill and stream-out order, the pointer wrap, and the fact that bytes sent after an end command never reach the register file.

// File: rtl/pnr_pkg.sv
// Shared constants and types for the parallel-port nibble register interface.
// Assumes the host protocol fixes a 4-bit payload, hence a 16-entry file.
package pnr_pkg;
    localparam int NIB_W  = 4;
    localparam int REG_AW = 4;
    localparam int NREGS  = 1 << REG_AW;

    localparam logic [2:0] CMD_DATA = 3'b000;
    localparam logic [2:0] CMD_WADR = 3'b010;
    localparam logic [2:0] CMD_RADR = 3'b110;
    localparam logic [2:0] CMD_END  = 3'b111;

    localparam logic [REG_AW-1:0] REG_CMD1 = 4'd12;
    localparam logic [REG_AW-1:0] REG_CMD2 = 4'd13;
    localparam logic [REG_AW-1:0] REG_BUF  = 4'd14;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WADR = 2'd1,
        PH_WDAT = 2'd2,
        PH_RDAT = 2'd3
    } phase_t;
endpackage

// File: rtl/pnr_decode.sv
// Byte decoder: splits a data-port byte into command, nibble select and
// payload, and flags an event only when the upper four bits change.
// Assumes host_wr is a one-cycle pulse per byte written by the host.
module pnr_decode
    import pnr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [7:0]       host_data,
    output logic             evt,
    output logic [2:0]       cmd,
    output logic             hi,
    output logic [NIB_W-1:0] pay
);
    logic [3:0] prev_top;

    // Remember the command and nibble-select bits of the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_top <= {CMD_END, 1'b0};
        else if (host_wr)
            prev_top <= host_data[7:4];
    end

    // Field split and change detection.
    always_comb begin
        cmd = host_data[7:5];
        hi  = host_data[4];
        pay = host_data[3:0];
        evt = host_wr && (host_data[7:4] != prev_top);
    end
endmodule

// File: rtl/pnr_regfile.sv
// Nibble-addressable register file with command decode of two entries.
// Assumes at most one nibble write per cycle; soft reset wins over it.
module pnr_regfile
    import pnr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic              whi,
    input  logic [NIB_W-1:0]  wnib,
    input  logic [REG_AW-1:0] raddr,
    input  logic              rhi,
    output logic [NIB_W-1:0]  rnib,
    output logic              soft_rst,
    output logic              tx_en,
    output logic              rx_en,
    output logic              mux,
    output logic [1:0]        acc
);
    logic [7:0] regs [NREGS];

    // Soft reset: high-nibble write to command-1 with its reset bit set.
    assign soft_rst = we && (waddr == REG_CMD1) && whi && wnib[2];

    // Register storage with hard reset, soft reset and nibble writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (soft_rst) begin
            regs[REG_CMD1] <= '0;
            regs[REG_CMD2] <= '0;
        end else if (we) begin
            if (whi) regs[waddr][7:4] <= wnib;
            else     regs[waddr][3:0] <= wnib;
        end
    end

    // Read nibble select and control field extraction.
    always_comb begin
        rnib  = rhi ? regs[raddr][7:4] : regs[raddr][3:0];
        mux   = regs[REG_CMD1][7];
        rx_en = regs[REG_CMD1][5];
        tx_en = regs[REG_CMD1][4];
        acc   = regs[REG_CMD2][5:4];
    end
endmodule

// File: rtl/pnr_bytebuf.sv
// Packet byte buffer filled from nibble pairs and read back by nibble.
// Assumes DEPTH is a power of two so the pointer wraps naturally.
module pnr_bytebuf
    import pnr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lo_we,
    input  logic             byte_we,
    input  logic             rd_adv,
    input  logic [NIB_W-1:0] pay,
    input  logic             rhi,
    output logic [NIB_W-1:0] rnib,
    output logic [PTR_W-1:0] ptr
);
    logic [7:0]       mem [DEPTH];
    logic [NIB_W-1:0] hold;

    // Capture the pending low nibble of a bulk byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold <= '0;
        else if (lo_we)  hold <= pay;
    end

    // Store a completed byte at the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        else if (byte_we)
            mem[ptr] <= {pay, hold};
    end

    // Pointer: clear on soft reset, step after each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           ptr <= '0;
        else if (byte_we || rd_adv)  ptr <= ptr + 1'b1;
    end

    // Nibble read at the pointer.
    assign rnib = rhi ? mem[ptr][7:4] : mem[ptr][3:0];
endmodule

// File: rtl/pnr_nibble_port.sv
// Top: access phase machine joining decoder, register file and buffer.
// Assumes one host byte per host_wr pulse; outputs settle one clock later.
module pnr_nibble_port
    import pnr_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    localparam int PTR_W = $clog2(BUF_DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    output logic [7:0] host_status,
    output logic       tx_enable,
    output logic       rx_enable,
    output logic       mux_sel,
    output logic [1:0] accept_mode
);
    logic              evt, hi, rd_hi, soft_rst;
    logic [2:0]        cmd;
    logic [NIB_W-1:0]  pay, reg_nib, buf_nib, rd_nib;
    logic [REG_AW-1:0] addr;
    logic [PTR_W-1:0]  buf_ptr;
    phase_t            phase;
    logic              reg_we, lo_we, byte_we, rd_adv;

    pnr_decode u_dec (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .evt(evt), .cmd(cmd), .hi(hi), .pay(pay)
    );

    // Access phase, latched address and read nibble select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            addr  <= '0;
            rd_hi <= 1'b0;
        end else if (evt) begin
            case (cmd)
                CMD_END:  phase <= PH_IDLE;
                CMD_WADR: begin addr <= pay; phase <= PH_WADR; end
                CMD_RADR: begin addr <= pay; rd_hi <= hi; phase <= PH_RDAT; end
                CMD_DATA: if (phase == PH_WADR || phase == PH_WDAT) phase <= PH_WDAT;
                default:  ;
            endcase
        end
    end

    // Strobes derived from the event and the current phase.
    always_comb begin
        reg_we  = evt && (cmd == CMD_DATA) && (phase == PH_WADR || phase == PH_WDAT);
        lo_we   = evt && (cmd == CMD_DATA) && (phase == PH_IDLE) && !hi;
        byte_we = evt && (cmd == CMD_DATA) && (phase == PH_IDLE) && hi;
        rd_adv  = evt && (phase == PH_RDAT) && (addr == REG_BUF) && rd_hi;
    end

    pnr_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(addr), .whi(hi),
        .wnib(pay), .raddr(addr), .rhi(rd_hi), .rnib(reg_nib),
        .soft_rst(soft_rst), .tx_en(tx_enable), .rx_en(rx_enable),
        .mux(mux_sel), .acc(accept_mode)
    );

    pnr_bytebuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .lo_we(lo_we),
        .byte_we(byte_we), .rd_adv(rd_adv), .pay(pay), .rhi(rd_hi),
        .rnib(buf_nib), .ptr(buf_ptr)
    );

    // Status lines: nibble on bits 6:3 while a read is open.
    always_comb begin
        rd_nib      = (addr == REG_BUF) ? buf_nib : reg_nib;
        host_status = (phase == PH_RDAT) ? {1'b0, rd_nib, 3'b000} : 8'h00;
    end
endmodule

// File: rtl/pnr_nibble_port_chk.sv
// Checker for pnr_nibble_port: protocol and pointer properties per cycle.
// Assumes it is bound into the top and sees the latched phase and address.
module pnr_nibble_port_chk
    import pnr_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [3:0]        hd_top,
    input logic              hd_b2,
    input logic [7:0]        host_status,
    input logic              tx_enable,
    input logic              rx_enable,
    input logic              mux_sel,
    input logic [1:0]        accept_mode,
    input phase_t            phase,
    input logic [REG_AW-1:0] wr_addr,
    input logic [PTR_W-1:0]  buf_ptr
);
    logic [3:0] last_top;

    // Independent record of the last written upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_top <= 4'hE;
        else if (host_wr) last_top <= hd_top;
    end

    // R2
    repeat_byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hd_top == last_top) |=>
        ($stable(host_status) && $stable(tx_enable) && $stable(rx_enable) &&
         $stable(mux_sel) && $stable(accept_mode) && $stable(buf_ptr)));

    // R6
    end_blanks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hd_top[3:1] == CMD_END) |=> (host_status == 8'h00));

    // R12
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (buf_ptr == $past(buf_ptr) ||
                  buf_ptr == PTR_W'($past(buf_ptr) + 1'b1) ||
                  buf_ptr == '0));

    // R11
    soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hd_top == 4'b0001 && last_top != 4'b0001 &&
         (phase == PH_WADR || phase == PH_WDAT) && wr_addr == REG_CMD1 && hd_b2)
        |=> (!tx_enable && !rx_enable && !mux_sel && accept_mode == 2'b00 &&
             buf_ptr == '0));
endmodule

bind pnr_nibble_port pnr_nibble_port_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .hd_top(host_data[7:4]),
    .hd_b2(host_data[2]), .host_status(host_status), .tx_enable(tx_enable),
    .rx_enable(rx_enable), .mux_sel(mux_sel), .accept_mode(accept_mode),
    .phase(phase), .wr_addr(addr), .buf_ptr(buf_ptr)
);

// File: tb/sim_pnr_nibble_port.sv
// Scoreboard bench: driver tasks push expected output bundles with a due
// cycle; a monitor pops and compares them away from the active edge.
module sim_pnr_nibble_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'hE0;
    logic [7:0] host_status;
    logic       tx_enable, rx_enable, mux_sel;
    logic [1:0] accept_mode;

    always #2 clk = ~clk;

    pnr_nibble_port u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .host_status(host_status), .tx_enable(tx_enable), .rx_enable(rx_enable),
        .mux_sel(mux_sel), .accept_mode(accept_mode)
    );

    typedef struct {
        int          due;
        logic [12:0] exp;
        string       tag;
    } item_t;

    item_t      q[$];
    int         cyc = 0, checks = 0, fails = 0;
    logic [7:0] mdl_reg [16];
    logic [7:0] mdl_buf [16];
    logic [3:0] mdl_ptr = '0;
    logic       e_tx = 0, e_rx = 0, e_mux = 0;
    logic [1:0] e_acc = '0;
    bit         done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare the observed bundle against due items.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [12:0] obs;
            it  = q.pop_front();
            obs = {host_status, mux_sel, rx_enable, tx_enable, accept_mode};
            checks++;
            if (obs !== it.exp) begin
                fails++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic upd_ctrl();
        e_tx  = mdl_reg[12][4];
        e_rx  = mdl_reg[12][5];
        e_mux = mdl_reg[12][7];
        e_acc = mdl_reg[13][5:4];
    endtask

    task automatic send(input logic [7:0] b);
        host_data = b;
        host_wr   = 1'b1;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    task automatic send_chk(input logic [7:0] b, input logic [3:0] nib,
                            input bit rd, input string tag);
        item_t it;
        it.due = cyc + 1;
        it.exp = {(rd ? {1'b0, nib, 3'b000} : 8'h00), e_mux, e_rx, e_tx, e_acc};
        it.tag = tag;
        q.push_back(it);
        send(b);
    endtask

    task automatic wr_nib(input logic [3:0] r, input logic [3:0] v,
                          input bit h, input string tag);
        logic [7:0] hb;
        hb = h ? 8'h10 : 8'h00;
        send(8'hE0 | hb | r); send(8'h40 | hb | r); send(8'h40 | hb | r);
        send(8'h40 | hb | v); send(hb | v); send(hb | v);
        if (h) mdl_reg[r][7:4] = v; else mdl_reg[r][3:0] = v;
        if (h && r == 4'd12 && v[2]) begin
            mdl_reg[12] = '0; mdl_reg[13] = '0; mdl_ptr = '0;
        end
        upd_ctrl();
        send_chk(8'hE0 | hb | v, 4'h0, 1'b0, tag);
    endtask

    task automatic wr_byte(input logic [3:0] r, input logic [7:0] b, input string tag);
        send(8'hE0 | r); send(8'h40 | r); send(8'h40 | r);
        send(8'h40 | b[3:0]); send({4'h0, b[3:0]}); send({4'h0, b[7:4]});
        send(8'h10 | b[7:4]); send(8'h10 | b[7:4]);
        mdl_reg[r] = b;
        upd_ctrl();
        send_chk(8'hE0 | b[7:4], 4'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] r, input bit h, input string tag);
        send_chk(8'hC0 | (h ? 8'h10 : 8'h00) | r,
                 h ? mdl_reg[r][7:4] : mdl_reg[r][3:0], 1'b1, tag);
    endtask

    task automatic bulk(input logic [7:0] b);
        send({4'h0, b[3:0]});
        send({4'h1, b[7:4]});
        mdl_buf[mdl_ptr] = b;
        mdl_ptr = mdl_ptr + 1'b1;
    endtask

    task automatic stream(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            send_chk(8'hCE, mdl_buf[mdl_ptr][3:0], 1'b1, tag);
            send_chk(8'hDE, mdl_buf[mdl_ptr][7:4], 1'b1, tag);
            mdl_ptr = mdl_ptr + 1'b1;
        end
        send_chk(8'hE0, 4'h0, 1'b0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 16; i++) begin mdl_reg[i] = '0; mdl_buf[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state (repeated reset-value byte causes no event)
        send_chk(8'hE0, 4'h0, 1'b0, "R1");
        rd(4'd5, 1'b0, "R1");
        send_chk(8'hE0, 4'h0, 1'b0, "R1");
        // R3, R5: low nibble write and read placement
        wr_nib(4'd3, 4'hA, 1'b0, "R3");
        rd(4'd3, 1'b0, "R5");
        rd(4'd3, 1'b1, "R5");
        // R2: payload-only change keeps the latched read address
        send_chk(8'hD7, mdl_reg[3][7:4], 1'b1, "R2");
        send_chk(8'hD7, mdl_reg[3][7:4], 1'b1, "R2");
        send_chk(8'hE0, 4'h0, 1'b0, "R6");
        // R4: high nibble write keeps the low nibble
        wr_nib(4'd3, 4'h5, 1'b1, "R4");
        rd(4'd3, 1'b1, "R4");
        rd(4'd3, 1'b0, "R4");
        // R13: whole byte in one access
        wr_byte(4'd7, 8'hC4, "R13");
        rd(4'd7, 1'b0, "R13");
        rd(4'd7, 1'b1, "R13");
        // R7, R8: control mapping
        wr_nib(4'd12, 4'hB, 1'b1, "R7");
        wr_nib(4'd13, 4'h2, 1'b1, "R8");
        wr_nib(4'd12, 4'h2, 1'b1, "R7");
        wr_nib(4'd13, 4'h3, 1'b1, "R8");
        // R9, R6: bulk bytes after an end go to the buffer, not reg 3
        send(8'hE0);
        bulk(8'h11); bulk(8'h2E); bulk(8'h93); bulk(8'h4C);
        rd(4'd3, 1'b0, "R6");
        rd(4'd3, 1'b1, "R6");
        send_chk(8'hE0, 4'h0, 1'b0, "R6");
        // R11: soft reset clears controls and pointer
        wr_nib(4'd12, 4'h4, 1'b1, "R11");
        rd(4'd13, 1'b1, "R11");
        // R10, R9: stream the filled bytes from the start
        stream(4, "R10");
        // R12: wrap after a full lap plus one
        wr_nib(4'd12, 4'h4, 1'b1, "R11");
        send(8'hE0);
        for (int i = 0; i < 17; i++) bulk(8'h30 + 8'(i));
        wr_nib(4'd12, 4'h4, 1'b1, "R12");
        stream(2, "R12");
        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule